// File: doc/BRIEF.md
# Top-of-Stack Register Renamer

This block holds the four uppermost stack elements in four fixed physical registers. Pushes and pops do not move data from one register to another. Instead, a two-bit name pointer rotates, so that the physical register seen as the top changes while the stored values stay where they are. A three-bit occupancy counter moves in step with the pointer. It tells control how many of the four registers hold live elements, and it signals when the top of the stack is only in memory.

Control code sees four logical names: A is the top, then B, C and D below it. A mapper adds the name pointer to a small displacement, taken from the low bits of a scratch-pad input, and then to the logical select. The result picks the physical register. A read through the mapper is purely combinational. A logical write goes to whichever physical register is mapped at that moment. A push stores its operand into the register that becomes the new top, on the same edge that rotates the pointer.

Top module: `tos_renamer`

## Requirements
- R1: While reset is asserted, the name pointer and the occupancy count are zero, `empty_o` is 1, and `ovf_o` and `unf_o` are 0.
- R2: Logical select L (0 = A/top, 1 = B, 2 = C, 3 = D) reads physical register (pointer + S + L) mod 4. S is bits [1:0] of `sp_i`, and the upper bits of `sp_i` have no effect.
- R3: A push that arrives without a pop while the count is below 4 decrements the pointer mod 4 and increments the count. It writes `push_data_i` into the physical register that becomes A, so the pushed value reads back as A (S = 0) after that edge.
- R4: A pop that arrives without a push while the count is above 0 increments the pointer mod 4 and decrements the count. No register is written, so the old B reads back as A.
- R5: `empty_o` is 1 exactly when the occupancy count is 0.
- R6: A push without a pop at count 4 is rejected. The pointer, the count and the registers are unchanged, and `ovf_o` is 1 for the following cycle only.
- R7: A pop without a push at count 0 is rejected. The pointer and the count are unchanged, and `unf_o` is 1 for the following cycle only.
- R8: A push and a pop in the same cycle change no pointer, count or register, and raise no flag.
- R9: `wr_en_i` writes `wr_data_i` into physical register (pointer + S + `wr_sel_i`) mod 4, using the pointer from before the edge. The pointer and the count do not change.
- R10: When a logical write and an accepted push fall in the same cycle, the write uses the mapping from before the push. If both target the same physical register, the push data is stored.
- R11: `rd_data_o` follows changes of `rd_sel_i` and `sp_i` within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_data_i | input | DATA_W | Operand stored by a push |
| sp_i | input | SP_W | Scratch-pad value; the low 2 bits give the displacement S |
| rd_sel_i | input | 2 | Logical register to read |
| rd_data_o | output | DATA_W | Contents of the selected logical register |
| wr_en_i | input | 1 | Logical register write enable |
| wr_sel_i | input | 2 | Logical register to write |
| wr_data_i | input | DATA_W | Data for a logical write |
| count_o | output | 3 | Occupancy count, 0 to 4 |
| empty_o | output | 1 | No element held in the registers |
| ovf_o | output | 1 | One-cycle pulse after a rejected push |
| unf_o | output | 1 | One-cycle pulse after a rejected pop |

## Verification
Two functions can land on the same edge: a logical write and an accepted push. The write decodes through the old pointer, while the push targets the slot that is about to become A. The bench drives both strobes in one cycle twice. The first time, the write selects D with zero displacement, which is the very register the push claims. The second time, the write selects A, a different register. The scoreboard model then predicts the read-back of every logical name: the push value must appear where they collide, and both values must appear where they do not.

// File: rtl/tos_pkg.sv
package tos_pkg;
  localparam int SLOTS = 4;
  localparam int PTR_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS + 1);

  typedef logic [PTR_W-1:0] slot_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BOTH = 2'd3
  } stk_op_e;
endpackage

// File: rtl/tos_name_ctrl.sv
module tos_name_ctrl
  import tos_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_i,
  input  logic  pop_i,
  output slot_t ptr_q,
  output cnt_t  cnt_q,
  output logic  push_ok,
  output slot_t push_slot,
  output logic  ovf_q,
  output logic  unf_q
);
  stk_op_e op;
  logic    full, pop_ok, upd_en;
  slot_t   ptr_d;
  cnt_t    cnt_d;
  logic    ovf_d, unf_d;

  assign op        = stk_op_e'({pop_i, push_i});
  assign full      = (cnt_q == cnt_t'(SLOTS));
  assign push_slot = ptr_q - slot_t'(1);

  always_comb begin
    push_ok = 1'b0;
    pop_ok  = 1'b0;
    ovf_d   = 1'b0;
    unf_d   = 1'b0;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    unique case (op)
      OP_PUSH: begin
        if (full) begin
          ovf_d = 1'b1;
        end else begin
          push_ok = 1'b1;
          ptr_d   = push_slot;
          cnt_d   = cnt_q + cnt_t'(1);
        end
      end
      OP_POP: begin
        if (cnt_q == '0) begin
          unf_d = 1'b1;
        end else begin
          pop_ok = 1'b1;
          ptr_d  = ptr_q + slot_t'(1);
          cnt_d  = cnt_q - cnt_t'(1);
        end
      end
      default: ;
    endcase
  end

  assign upd_en = push_ok | pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (upd_en) begin
        ptr_q <= ptr_d;
        cnt_q <= cnt_d;
      end
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end
endmodule

// File: rtl/tos_mapper.sv
module tos_mapper
  import tos_pkg::*;
(
  input  slot_t ptr,
  input  slot_t disp,
  input  slot_t lsel,
  output slot_t phys
);
  slot_t code;

  assign code = ptr + disp;
  assign phys = code + lsel;
endmodule

// File: rtl/tos_regfile.sv
module tos_regfile
  import tos_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wa_en,
  input  slot_t             wa_slot,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  slot_t             wb_slot,
  input  logic [DATA_W-1:0] wb_data,
  input  slot_t             rd_slot,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rd_bus [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              en;
    logic [DATA_W-1:0] d, q;

    always_comb begin
      en = 1'b0;
      d  = q;
      if (wa_en && wa_slot == slot_t'(s)) begin
        en = 1'b1;
        d  = wa_data;
      end
      if (wb_en && wb_slot == slot_t'(s)) begin
        en = 1'b1;
        d  = wb_data;
      end
    end

    always_ff @(posedge clk) begin
      if (en) q <= d;
    end

    assign rd_bus[s] = q;
  end

  assign rd_data = rd_bus[rd_slot];
endmodule

// File: rtl/tos_renamer.sv
module tos_renamer
  import tos_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [2:0]        count_o,
  output logic              empty_o,
  output logic              ovf_o,
  output logic              unf_o
);
  slot_t ptr_q, push_slot, rd_phys, wr_phys, disp;
  cnt_t  cnt_q;
  logic  push_ok;

  assign disp = sp_i[PTR_W-1:0];

  tos_name_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .ptr_q     (ptr_q),
    .cnt_q     (cnt_q),
    .push_ok   (push_ok),
    .push_slot (push_slot),
    .ovf_q     (ovf_o),
    .unf_q     (unf_o)
  );

  tos_mapper u_rd_map (
    .ptr  (ptr_q),
    .disp (disp),
    .lsel (rd_sel_i),
    .phys (rd_phys)
  );

  tos_mapper u_wr_map (
    .ptr  (ptr_q),
    .disp (disp),
    .lsel (wr_sel_i),
    .phys (wr_phys)
  );

  tos_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .wa_en   (wr_en_i),
    .wa_slot (wr_phys),
    .wa_data (wr_data_i),
    .wb_en   (push_ok),
    .wb_slot (push_slot),
    .wb_data (push_data_i),
    .rd_slot (rd_phys),
    .rd_data (rd_data_o)
  );

  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/tos_renamer_chk.sv
module tos_renamer_chk #(
  parameter int DATA_W = 16,
  parameter int SP_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] push_data_i,
  input logic [SP_W-1:0]   sp_i,
  input logic [1:0]        rd_sel_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              wr_en_i,
  input logic [2:0]        count_o,
  input logic              empty_o,
  input logic              ovf_o,
  input logic              unf_o,
  input logic [1:0]        ptr_q
);
  logic push_only, pop_only;
  assign push_only = push_i && !pop_i;
  assign pop_only  = pop_i && !push_i;

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> (count_o == 3'd0 && ptr_q == 2'd0 && !ovf_o && !unf_o)));

  a_r3_push_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    (push_only && count_o < 3'd4) |=>
      (ptr_q == 2'($past(ptr_q) - 2'd1) && count_o == $past(count_o) + 3'd1));

  a_r3_push_is_top: assert property (@(posedge clk) disable iff (!rst_n)
    (push_only && count_o < 3'd4) |=>
      (!(rd_sel_i == 2'd0 && sp_i[1:0] == 2'd0) || rd_data_o == $past(push_data_i)));

  a_r4_pop_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_only && count_o != 3'd0) |=>
      (ptr_q == 2'($past(ptr_q) + 2'd1) && count_o == $past(count_o) - 3'd1));

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= 3'd4);

  a_r5_empty_after_last_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_only && count_o == 3'd1) |=> empty_o);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_only && count_o == 3'd4) |=> (ovf_o && $stable(count_o) && $stable(ptr_q)));

  a_r6_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(push_only));

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_only && count_o == 3'd0) |=> (unf_o && $stable(count_o) && $stable(ptr_q)));

  a_r8_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> ($stable(count_o) && $stable(ptr_q) && !ovf_o && !unf_o));

  a_r9_write_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !push_i && !pop_i) |=> ($stable(count_o) && $stable(ptr_q)));

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ovf_o, unf_o}) <= 1);
endmodule

bind tos_renamer tos_renamer_chk #(.DATA_W(DATA_W), .SP_W(SP_W)) u_chk (.*);

// File: tb/sim_tos_renamer.sv
module sim_tos_renamer;
  localparam int  DATA_W = 16;
  localparam int  SP_W   = 8;
  localparam time CLK_T  = 10;

  logic              clk, rst_n;
  logic              push_i, pop_i, wr_en_i;
  logic [DATA_W-1:0] push_data_i, wr_data_i, rd_data_o;
  logic [SP_W-1:0]   sp_i;
  logic [1:0]        rd_sel_i, wr_sel_i;
  logic [2:0]        count_o;
  logic              empty_o, ovf_o, unf_o;

  tos_renamer #(.DATA_W(DATA_W), .SP_W(SP_W)) u0 (.*);

  initial clk = 1'b0;
  always #(CLK_T / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    string req;
    int    cnt;
    bit    emp, ovf, unf, crd;
    int    rd;
  } exp_t;
  exp_t sb[$];

  int mptr, mcnt;
  int mreg [4];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.req, " count"}, int'(count_o), e.cnt);
      chk({e.req, " empty"}, int'(empty_o), int'(e.emp));
      chk({e.req, " ovf"}, int'(ovf_o), int'(e.ovf));
      chk({e.req, " unf"}, int'(unf_o), int'(e.unf));
      if (e.crd) chk({e.req, " rd_data"}, int'(rd_data_o), e.rd);
    end
  end

  task automatic op(string req, bit pu, bit po, int pd, bit we, int ws,
                    int wd, int sp, int rs, bit crd);
    exp_t e;
    int   wslot;
    @(negedge clk);
    push_i = pu; pop_i = po; push_data_i = DATA_W'(pd);
    wr_en_i = we; wr_sel_i = 2'(ws); wr_data_i = DATA_W'(wd);
    sp_i = SP_W'(sp); rd_sel_i = 2'(rs);
    e.ovf = 0; e.unf = 0;
    wslot = (mptr + sp + ws) & 3;
    if (we) mreg[wslot] = wd;
    if (pu && !po) begin
      if (mcnt == 4) e.ovf = 1;
      else begin
        mptr = (mptr + 3) & 3;
        mreg[mptr] = pd;
        mcnt++;
      end
    end else if (po && !pu) begin
      if (mcnt == 0) e.unf = 1;
      else begin
        mptr = (mptr + 1) & 3;
        mcnt--;
      end
    end
    e.req = req; e.cnt = mcnt; e.emp = (mcnt == 0); e.crd = crd;
    e.rd  = mreg[(mptr + sp + rs) & 3] & ((1 << DATA_W) - 1);
    sb.push_back(e);
  endtask

  task automatic idle(string req, int sp, int rs, bit crd);
    op(req, 0, 0, 0, 0, 0, 0, sp, rs, crd);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    push_i = 0; pop_i = 0; wr_en_i = 0; push_data_i = '0; wr_data_i = '0;
    sp_i = '0; rd_sel_i = '0; wr_sel_i = '0;
    mptr = 0; mcnt = 0;
    for (int i = 0; i < 4; i++) mreg[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count", int'(count_o), 0);
    chk("R1 empty", int'(empty_o), 1);
    chk("R1 ovf", int'(ovf_o), 0);
    chk("R1 unf", int'(unf_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    idle("R5 idle empty", 0, 0, 0);
    op("R7 pop on empty", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    idle("R7 flag drops", 0, 0, 0);

    op("R3 push 1", 1, 0, 16'h1111, 0, 0, 0, 0, 0, 1);
    op("R3 push 2", 1, 0, 16'h2222, 0, 0, 0, 0, 0, 1);
    op("R3 push 3", 1, 0, 16'h3333, 0, 0, 0, 0, 0, 1);
    op("R3 push 4", 1, 0, 16'h4444, 0, 0, 0, 0, 0, 1);
    op("R6 push when full", 1, 0, 16'hdead, 0, 0, 0, 0, 0, 1);
    idle("R6 flag drops", 0, 3, 1);

    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 4; r++)
        idle("R2 mapping", s | 8'hA4, r, 1);

    op("R8 push and pop", 1, 1, 16'hbeef, 0, 0, 0, 0, 0, 1);
    for (int r = 0; r < 4; r++) idle("R8 regs kept", 0, r, 1);

    op("R9 write B", 0, 0, 0, 1, 1, 16'h5a5a, 0, 1, 1);
    op("R9 write D with disp 1", 0, 0, 0, 1, 2, 16'h0f0f, 1, 3, 1);
    for (int r = 0; r < 4; r++) idle("R9 readback", 0, r, 1);

    op("R4 pop", 0, 1, 0, 0, 0, 0, 0, 0, 1);
    for (int r = 0; r < 3; r++) idle("R4 readback", 0, r, 1);

    op("R10 write D + push collide", 1, 0, 16'h7777, 1, 3, 16'h9999, 0, 0, 1);
    for (int r = 0; r < 4; r++) idle("R10 collide readback", 0, r, 1);

    op("R4 pop a", 0, 1, 0, 0, 0, 0, 0, 0, 1);
    op("R4 pop b", 0, 1, 0, 0, 0, 0, 0, 0, 1);
    op("R10 write A + push apart", 1, 0, 16'h6666, 1, 0, 16'h8888, 0, 0, 1);
    for (int r = 0; r < 3; r++) idle("R10 apart readback", 0, r, 1);

    @(negedge clk);
    push_i = 0; pop_i = 0; wr_en_i = 0;
    sp_i = 8'h00; rd_sel_i = 2'd1;
    #1 chk("R11 comb sel B", int'(rd_data_o), mreg[(mptr + 1) & 3]);
    rd_sel_i = 2'd0; sp_i = 8'hF2;
    #1 chk("R11 comb disp 2", int'(rd_data_o), mreg[(mptr + 2) & 3]);

    op("R4 pop c", 0, 1, 0, 0, 0, 0, 0, 0, 1);
    op("R4 pop d", 0, 1, 0, 0, 0, 0, 0, 0, 1);
    op("R5 pop to empty", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    op("R7 pop past empty", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    idle("R5 still empty", 0, 0, 0);

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule